// File: doc/BRIEF.md
# Torus Next-Hop Direction Selector

This block decides where a packet goes next in a three-dimensional wraparound mesh. The mesh has three rings, one per dimension, and each node has two links on each ring. A request gives the logical number of the node doing the routing and the logical number of the target node. Both numbers pass through a small remap table that turns logical node numbers into physical ones. That table lets a failed physical node be swapped out of the logical space without changing any software addressing. The block then compares the two physical positions ring by ring.

For each ring it works out the signed number of hops along the shorter way round. The first ring, in X-Y-Z order, that still has distance left picks the output link. A packet that is already at its target is marked for local delivery. Each answer is registered and comes out one cycle after the request. The remap table has a write port that is meant to be used while no routing is in progress.

Top module: `torus_route`

## Requirements
- R1: After reset, rsp_valid is 0, rsp_port is 0 and the three offsets are 0. Every remap entry holds its own index, so logical node n maps to physical node n.
- R2: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high, and low otherwise. Requests in consecutive cycles give responses in consecutive cycles.
- R3: A node number is {z, y, x} with x in the low CW bits, where CW = clog2(RING). Each offset is the signed hop count, along the shorter way round that ring, from the physical source coordinate to the physical target coordinate.
- R4: When both ways round a ring are equally long, the offset is +RING/2. No offset is ever below -(RING-1)/2 or above RING/2.
- R5: rsp_port gives the first ring in the order X, Y, Z whose offset is non-zero. The codes are 1 = X+, 2 = X-, 3 = Y+, 4 = Y-, 5 = Z+ and 6 = Z-, and the sign of that ring's offset picks + or -.
- R6: When all three offsets are zero, rsp_port is 0 (deliver locally).
- R7: A cycle with tbl_we high stores tbl_data as the physical number for logical node tbl_addr. From the next cycle on, both the source lookup and the target lookup use the new entry.
- R8: A request made in the same cycle as a table write uses the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Remap table write strobe |
| tbl_addr | input | NW | Logical node number to remap |
| tbl_data | input | NW | Physical node number to store |
| req_valid | input | 1 | Route request strobe |
| req_here | input | NW | Logical number of the routing node |
| req_dest | input | NW | Logical number of the target node |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_port | output | 3 | Chosen link code, or 0 for local delivery |
| rsp_off_x | output | CW+1 | Signed X hop count |
| rsp_off_y | output | CW+1 | Signed Y hop count |
| rsp_off_z | output | CW+1 | Signed Z hop count |

## Verification
A remap write and a route lookup can happen in the same cycle. The bench provokes this by raising tbl_we and req_valid on the same falling edge, with the write changing the entry that the request's target looks up. The expected response is built from the bench's copy of the table taken before the write. The bench copy is updated only after that, and a second request to the same target must then reflect the new physical position.

// File: rtl/torus_pkg.sv
package torus_pkg;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_XP    = 3'd1,
        PORT_XM    = 3'd2,
        PORT_YP    = 3'd3,
        PORT_YM    = 3'd4,
        PORT_ZP    = 3'd5,
        PORT_ZM    = 3'd6
    } route_port_e;

    typedef struct packed {
        logic        valid;
        route_port_e port;
    } route_rsp_t;

    // nz: ring has distance left, neg: offset negative; index 0 = X
    function automatic route_port_e pick_port(input logic [2:0] nz, input logic [2:0] neg);
        if (nz[0]) return neg[0] ? PORT_XM : PORT_XP;
        if (nz[1]) return neg[1] ? PORT_YM : PORT_YP;
        if (nz[2]) return neg[2] ? PORT_ZM : PORT_ZP;
        return PORT_LOCAL;
    endfunction

endpackage

// File: rtl/torus_map_table.sv
module torus_map_table #(
    parameter int NW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [NW-1:0] waddr,
    input  logic [NW-1:0] wdata,
    input  logic [NW-1:0] raddr_a,
    output logic [NW-1:0] rdata_a,
    input  logic [NW-1:0] raddr_b,
    output logic [NW-1:0] rdata_b
);
    localparam int DEPTH = 1 << NW;

    logic [NW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= NW'(i);
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R7
    tbl_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/torus_ring_offset.sv
module torus_ring_offset #(
    parameter int RING = 4,
    parameter int CW   = 2
) (
    input  logic [CW-1:0]        here,
    input  logic [CW-1:0]        dest,
    output logic signed [CW:0]   off
);
    localparam logic [CW:0] RING_W = (CW+1)'(RING);

    logic [CW:0] fwd;
    logic [CW:0] back;

    always_comb begin
        if (dest >= here) begin
            fwd = {1'b0, dest} - {1'b0, here};
        end else begin
            fwd = {1'b0, dest} + RING_W - {1'b0, here};
        end
        back = RING_W - fwd;
        if (fwd == '0) begin
            off = '0;
        end else if (fwd <= back) begin
            off = $signed(fwd);
        end else begin
            off = -$signed(back);
        end
    end

endmodule

// File: rtl/torus_route.sv
module torus_route
    import torus_pkg::*;
#(
    parameter int RING = 4,
    parameter int CW   = $clog2(RING),
    parameter int NW   = 3 * CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tbl_we,
    input  logic [NW-1:0] tbl_addr,
    input  logic [NW-1:0] tbl_data,
    input  logic          req_valid,
    input  logic [NW-1:0] req_here,
    input  logic [NW-1:0] req_dest,
    output logic          rsp_valid,
    output logic [2:0]    rsp_port,
    output logic [CW:0]   rsp_off_x,
    output logic [CW:0]   rsp_off_y,
    output logic [CW:0]   rsp_off_z
);
    localparam int DIMS = 3;

    logic [NW-1:0]      phys_here;
    logic [NW-1:0]      phys_dest;
    logic signed [CW:0] off_c [DIMS];
    logic signed [CW:0] off_q [DIMS];
    logic [DIMS-1:0]    nz_c;
    logic [DIMS-1:0]    neg_c;
    route_rsp_t         rsp_q;

    torus_map_table #(.NW(NW)) u_map (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .waddr  (tbl_addr),
        .wdata  (tbl_data),
        .raddr_a(req_here),
        .rdata_a(phys_here),
        .raddr_b(req_dest),
        .rdata_b(phys_dest)
    );

    for (genvar g = 0; g < DIMS; g++) begin : g_ring
        torus_ring_offset #(.RING(RING), .CW(CW)) u_off (
            .here(phys_here[g*CW +: CW]),
            .dest(phys_dest[g*CW +: CW]),
            .off (off_c[g])
        );
        assign nz_c[g]  = (off_c[g] != '0);
        assign neg_c[g] = off_c[g][CW];

        // R4
        off_bound_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_valid |-> (2 * int'(off_q[g]) <= RING && -2 * int'(off_q[g]) < RING));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '{valid: 1'b0, port: PORT_LOCAL};
            for (int d = 0; d < DIMS; d++) off_q[d] <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            if (req_valid) begin
                rsp_q.port <= pick_port(nz_c, neg_c);
                for (int d = 0; d < DIMS; d++) off_q[d] <= off_c[d];
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_port  = rsp_q.port;
    assign rsp_off_x = off_q[0];
    assign rsp_off_y = off_q[1];
    assign rsp_off_z = off_q[2];

    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R6
    local_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_port == PORT_LOCAL) |->
            (rsp_off_x == '0 && rsp_off_y == '0 && rsp_off_z == '0));

    // R5
    order_y_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_port == PORT_YP || rsp_port == PORT_YM)) |->
            (rsp_off_x == '0 && rsp_off_y != '0));

    // R5
    order_z_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_port == PORT_ZP || rsp_port == PORT_ZM)) |->
            (rsp_off_x == '0 && rsp_off_y == '0 && rsp_off_z != '0));

endmodule

// File: tb/torus_route_tb.sv
`timescale 1ns/1ps
module torus_route_tb;
    localparam int RING = 4;
    localparam int CW   = 2;
    localparam int NW   = 6;
    localparam int NODES = 1 << NW;

    typedef struct {
        int    port;
        int    ox;
        int    oy;
        int    oz;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tbl_we = 1'b0;
    logic [NW-1:0] tbl_addr = '0;
    logic [NW-1:0] tbl_data = '0;
    logic          req_valid = 1'b0;
    logic [NW-1:0] req_here = '0;
    logic [NW-1:0] req_dest = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_port;
    logic [CW:0]   rsp_off_x;
    logic [CW:0]   rsp_off_y;
    logic [CW:0]   rsp_off_z;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   shadow [NODES];
    exp_t sb [$];
    bit   done = 1'b0;

    always #2 clk = ~clk;

    torus_route #(.RING(RING)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .tbl_data (tbl_data),
        .req_valid(req_valid),
        .req_here (req_here),
        .req_dest (req_dest),
        .rsp_valid(rsp_valid),
        .rsp_port (rsp_port),
        .rsp_off_x(rsp_off_x),
        .rsp_off_y(rsp_off_y),
        .rsp_off_z(rsp_off_z)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int node(input int x, input int y, input int z);
        return z * RING * RING + y * RING + x;
    endfunction

    // shorter signed way round one ring, tie goes positive (R3, R4)
    function automatic int ring_off(input int h, input int d);
        int f;
        f = ((d - h) % RING + RING) % RING;
        if (f == 0) return 0;
        if (f <= RING - f) return f;
        return f - RING;
    endfunction

    function automatic exp_t model(input int here, input int dest, input string req);
        exp_t e;
        int ph, pd;
        ph = shadow[here];
        pd = shadow[dest];
        e.ox = ring_off(ph % RING, pd % RING);
        e.oy = ring_off((ph / RING) % RING, (pd / RING) % RING);
        e.oz = ring_off(ph / (RING * RING), pd / (RING * RING));
        if (e.ox != 0)      e.port = (e.ox > 0) ? 1 : 2;
        else if (e.oy != 0) e.port = (e.oy > 0) ? 3 : 4;
        else if (e.oz != 0) e.port = (e.oz > 0) ? 5 : 6;
        else                e.port = 0;
        e.req = req;
        return e;
    endfunction

    task automatic send(input int here, input int dest, input string req);
        @(negedge clk);
        tbl_we    = 1'b0;
        req_valid = 1'b1;
        req_here  = NW'(here);
        req_dest  = NW'(dest);
        sb.push_back(model(here, dest, req));
    endtask

    task automatic idle();
        @(negedge clk);
        tbl_we    = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic load(input int addr, input int data);
        @(negedge clk);
        req_valid = 1'b0;
        tbl_we    = 1'b1;
        tbl_addr  = NW'(addr);
        tbl_data  = NW'(data);
        shadow[addr] = data;
    endtask

    // R8: write and request in one cycle, expectation from the old table
    task automatic load_and_send(input int addr, input int data, input int here, input int dest);
        @(negedge clk);
        tbl_we    = 1'b1;
        tbl_addr  = NW'(addr);
        tbl_data  = NW'(data);
        req_valid = 1'b1;
        req_here  = NW'(here);
        req_dest  = NW'(dest);
        sb.push_back(model(here, dest, "R8"));
        shadow[addr] = data;
    endtask

    // monitor: compare every response against the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(rsp_port) == e.port, e.req, "port", int'(rsp_port), e.port);
                    check(int'($signed(rsp_off_x)) == e.ox, e.req, "off_x", int'($signed(rsp_off_x)), e.ox);
                    check(int'($signed(rsp_off_y)) == e.oy, e.req, "off_y", int'($signed(rsp_off_y)), e.oy);
                    check(int'($signed(rsp_off_z)) == e.oz, e.req, "off_z", int'($signed(rsp_off_z)), e.oz);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            check(1'b0, "watchdog", "run did not finish", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        for (int i = 0; i < NODES; i++) shadow[i] = i;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
        check(rsp_port == 3'd0, "R1", "rsp_port", int'(rsp_port), 0);
        check(rsp_off_x == '0 && rsp_off_y == '0 && rsp_off_z == '0, "R1", "offsets", int'(rsp_off_x), 0);

        // R1/R3 identity table, mixed offsets: expect X+ with +1,+2,+1
        send(node(2, 0, 3), node(3, 2, 0), "R3");
        // R6 local delivery
        send(node(1, 2, 3), node(1, 2, 3), "R6");
        // R5 X done, Y backwards
        send(node(1, 1, 1), node(1, 0, 1), "R5");
        // R5 only Z left, forward and backward
        send(node(0, 3, 2), node(0, 3, 3), "R5");
        send(node(0, 3, 0), node(0, 3, 3), "R5");
        // R4 tie on X goes positive
        send(node(0, 0, 0), node(2, 0, 0), "R4");
        // R4 tie on Z after X, Y equal
        send(node(3, 1, 3), node(3, 1, 1), "R4");
        // R3 wrap backwards on X
        send(node(0, 2, 2), node(3, 1, 2), "R3");
        idle();
        idle();
        // R2 no response while idle
        check(rsp_valid == 1'b0, "R2", "idle rsp_valid", int'(rsp_valid), 0);

        // R7 remap target and source
        load(node(3, 3, 3), node(1, 0, 0));
        load(node(1, 0, 0), node(0, 2, 0));
        send(node(0, 0, 0), node(3, 3, 3), "R7");
        send(node(1, 0, 0), node(0, 0, 0), "R7");
        send(node(1, 0, 0), node(3, 3, 3), "R7");
        idle();

        // R8 same-cycle write and request, then the new mapping
        load_and_send(node(2, 0, 0), node(0, 0, 3), node(0, 0, 0), node(2, 0, 0));
        send(node(0, 0, 0), node(2, 0, 0), "R8");
        idle();

        // R2/R3 back-to-back stream of varied pairs
        seed = 32'h2F1D;
        for (int k = 0; k < 40; k++) begin
            int a, b;
            seed = seed * 1103515245 + 12345;
            a = (seed >>> 8) & (NODES - 1);
            b = (seed >>> 16) & (NODES - 1);
            send(a, b, "R3");
        end
        idle();
        idle();
        idle();
        check(sb.size() == 0, "R2", "responses outstanding", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule